// File: doc/BRIEF.md
# Fractional Pre-Divided Master Clock Enable Generator

This block turns a reference clock into a periodic single-cycle enable pulse, as needed for a display pixel clock or an audio master clock. The block runs in a domain clocked at twice the rate of the chosen source. A half-integer pre-division of 2, 2.5 or 3 is therefore a whole count of 4, 5 or 6 doubled-reference cycles. A 7-bit integer divider follows the pre-divider, so the pulse rate is twice the source rate divided by (pre-divider code + 3) times the integer divisor.

Software writes one 32-bit configuration word with a write strobe. The word holds the enable, a source-select field, the pre-divider code and the integer divisor. Source selection is only decoded and reported on a status output. The switch between asynchronous sources happens outside this block. Every write clears both counters, so the first pulse after a write comes one full new period later.

Top module: `frac_mclk_gen`

## Requirements
- R1: After reset the pulse output is low and the source status reads crystal (code 0).
- R2: The pre-divider code sits in word bits 9:8. Codes 1, 2 and 3 give runs of 4, 5 and 6 doubled-reference cycles per integer step. The pulse period in cycles is therefore (code + 3) × divisor.
- R3: Pre-divider code 0 stops the pulse output even when the enable bit is set.
- R4: The integer divisor sits in word bits 6:0 and covers 1 to 127. A divisor of zero produces no pulse.
- R5: Word bit 15 enables the divider. While it is clear the pulse output stays low.
- R6: Word bit 7 and the other unassigned bits have no effect on the pulse output or on the source status.
- R7: The source field is word bits 14:13. Pattern 10 reports first PLL (code 1), 11 reports second PLL (code 2), and 00 or 01 report crystal (code 0). The status never reads 3.
- R8: A write clears both counters. Count the clock edge that loads the word as edge 1. The first pulse is then high in the cycle that follows edge (code + 3) × divisor, and later pulses follow every period.
- R9: Each pulse is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock at twice the selected source rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Configuration word (enable, source, pre-divider, divisor) |
| cfg_wr | input | 1 | Write strobe; loads cfg_word and clears the counters |
| src_status | output | 2 | Decoded source: 0 crystal, 1 first PLL, 2 second PLL |
| mclk_en | output | 1 | Single-cycle enable pulse at the divided rate |

## Verification
The bench builds the block with its default parameters: a 2-bit pre-divider code, a 7-bit divisor and the standard field positions. The longest period is therefore 6 × 127 = 762 cycles. With this bound the bench can observe two full periods for every divisor up to 127, including the top corner. Each pulse position is compared cycle by cycle against a period computed in the bench, for directed words and for seeded random words. These words cover the zero codes, the cleared enable, the reserved bit, every source pattern and a rewrite in the middle of a period.

// File: rtl/frac_mclk_pkg.sv
// Shared types for the fractional master clock enable generator.
// Assumes the source codes are only reported, never used to switch clocks here.
package frac_mclk_pkg;
    typedef enum logic [1:0] {
        SRC_XTAL  = 2'd0,
        SRC_PLL_A = 2'd1,
        SRC_PLL_B = 2'd2
    } src_e;
endpackage

// File: rtl/frac_mclk_cfg.sv
// Configuration holder: registers the control word on a write strobe and
// decodes the enable, source, pre-divider code and integer divisor fields.
// Assumes the field positions are given by parameters and do not overlap.
module frac_mclk_cfg
    import frac_mclk_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int PRE_W   = 2,
    parameter int DIV_W   = 7,
    parameter int DIV_LSB = 0,
    parameter int PRE_LSB = 8,
    parameter int SEL_LSB = 13,
    parameter int EN_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_stb,
    output logic              en_bit,
    output logic [PRE_W-1:0]  pre_code,
    output logic [DIV_W-1:0]  div_val,
    output src_e              src
);
    logic [WORD_W-1:0] word_q;
    logic [1:0]        sel_raw;

    // Hold the last written word; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (wr_stb) word_q <= wr_word;
    end

    // Pick the fields out of the stored word and decode the source pattern.
    always_comb begin
        en_bit   = word_q[EN_BIT];
        pre_code = word_q[PRE_LSB +: PRE_W];
        div_val  = word_q[DIV_LSB +: DIV_W];
        sel_raw  = word_q[SEL_LSB +: 2];
        case (sel_raw)
            2'b10:   src = SRC_PLL_A;
            2'b11:   src = SRC_PLL_B;
            default: src = SRC_XTAL;
        endcase
    end

    assert_src_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        src != 2'd3);
endmodule

// File: rtl/frac_mclk_prediv.sv
// Pre-divider: counts (code + 3) doubled-reference cycles and raises a
// terminal tick on the last one. Assumes the caller holds run low for code 0.
module frac_mclk_prediv #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int MAX_CNT = (2 ** PRE_W) - 1 + 3;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Last count value of one pre-divider run.
    always_comb lim = CNT_W'(code) + CNT_W'(2);

    // Step through one run; restart on write, idle or terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt <= '0;
        else if (cnt == lim)       cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == lim);

    assert_prediv_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim));
    assert_prediv_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/frac_mclk_intdiv.sv
// Integer divider: advances once per pre-divider tick and flags the tick
// that closes a full divisor count. Assumes run is low for a divisor of 0.
module frac_mclk_intdiv #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             last
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] top;

    // Last count value before wrapping.
    always_comb top = div - 1'b1;

    // Count pre-divider ticks; restart on write, idle or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt <= '0;
        else if (step) begin
            if (cnt == top) cnt <= '0;
            else            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && step && (cnt == top);

    assert_intdiv_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    assert_intdiv_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= top));
endmodule

// File: rtl/frac_mclk_gen.sv
// Top: fractional pre-divided master clock enable generator. Runs at twice
// the source rate; emits one-cycle pulses every (code + 3) * divisor cycles.
// Assumes the selected source is switched outside; src_status only reports it.
module frac_mclk_gen
    import frac_mclk_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int PRE_W   = 2,
    parameter int DIV_W   = 7,
    parameter int DIV_LSB = 0,
    parameter int PRE_LSB = 8,
    parameter int SEL_LSB = 13,
    parameter int EN_BIT  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              cfg_wr,
    output logic [1:0]        src_status,
    output logic              mclk_en
);
    logic             en_bit;
    logic [PRE_W-1:0] pre_code;
    logic [DIV_W-1:0] div_val;
    src_e             src;
    logic             active;
    logic             pre_tick;

    frac_mclk_cfg #(
        .WORD_W(WORD_W), .PRE_W(PRE_W), .DIV_W(DIV_W),
        .DIV_LSB(DIV_LSB), .PRE_LSB(PRE_LSB), .SEL_LSB(SEL_LSB), .EN_BIT(EN_BIT)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_word(cfg_word), .wr_stb(cfg_wr),
        .en_bit(en_bit), .pre_code(pre_code), .div_val(div_val), .src(src)
    );

    // Run only when enabled with a non-zero pre-divider and divisor.
    always_comb active = en_bit && (pre_code != '0) && (div_val != '0);

    frac_mclk_prediv #(.PRE_W(PRE_W)) prediv_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .run(active),
        .code(pre_code), .tick(pre_tick)
    );

    frac_mclk_intdiv #(.DIV_W(DIV_W)) intdiv_i (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .run(active),
        .step(pre_tick), .div(div_val), .last(mclk_en)
    );

    assign src_status = src;

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |=> !mclk_en);
    assert_pulse_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> en_bit);
    assert_pulse_needs_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> (pre_code != '0));
endmodule

// File: tb/frac_mclk_gen_tb.sv
// Bench: directed corner words plus seeded random words; each cycle's pulse
// is compared against a period computed from the requirements.
// The 125 MHz clock stands for the doubled source rate.
`timescale 1ns/1ps
module frac_mclk_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  src_status;
    logic        mclk_en;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    frac_mclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr),
        .src_status(src_status), .mclk_en(mclk_en)
    );

    always #4 clk = ~clk;

    // Period in cycles (R2, R3, R4, R5); zero means no pulse at all.
    function automatic int exp_period(input logic [31:0] w);
        int code = int'(w[9:8]);
        int dv   = int'(w[6:0]);
        if (!w[15] || code == 0 || dv == 0) return 0;
        return (code + 3) * dv;
    endfunction

    // Source status code from bits 14:13 (R7).
    function automatic logic [1:0] exp_src(input logic [31:0] w);
        case (w[14:13])
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Load a word; returns at the negedge after the loading edge.
    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cfg_word = w;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
        check(src_status == exp_src(w), "R7 source status", int'(src_status), int'(exp_src(w)));
    endtask

    // Compare the pulse for n cycles after a write (R8 timing, R9 width).
    task automatic observe(input logic [31:0] w, input int n, input string req);
        int p = exp_period(w);
        for (int m = 0; m < n; m++) begin
            bit e = (p != 0) && (((m + 1) % p) == 0);
            check(mclk_en == e, req, int'(mclk_en), int'(e));
            @(negedge clk);
        end
    endtask

    function automatic int span(input logic [31:0] w);
        int p = exp_period(w);
        return (p == 0) ? 40 : 2 * p + 3;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mclk_en == 1'b0, "R1 pulse low in reset", int'(mclk_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mclk_en == 1'b0, "R1 pulse low after reset", int'(mclk_en), 0);
        check(src_status == 2'd0, "R1 source crystal after reset", int'(src_status), 0);

        // R2: each pre-divider code with divisor 1 and 3
        for (int c = 1; c < 4; c++) begin
            w = 32'h0000_8000 | (32'(c) << 8) | 32'd1;
            write_word(w); observe(w, span(w), "R2 prediv code, div 1");
            w = 32'h0000_8000 | (32'(c) << 8) | 32'd3;
            write_word(w); observe(w, span(w), "R2 prediv code, div 3");
        end
        // R4: divisor top corner and zero
        w = 32'h0000_8000 | (32'd3 << 8) | 32'd127;
        write_word(w); observe(w, span(w), "R4 divisor 127");
        w = 32'h0000_8000 | (32'd2 << 8);
        write_word(w); observe(w, 60, "R4 divisor zero silent");
        // R3: code zero with enable set
        w = 32'h0000_8000 | 32'd5;
        write_word(w); observe(w, 60, "R3 prediv code zero silent");
        // R5: enable clear
        w = (32'd1 << 8) | 32'd2;
        write_word(w); observe(w, 60, "R5 enable clear silent");
        // R6: reserved bit 7 and upper bits set, period unchanged
        w = 32'hFFFF_0000 | 32'h0000_8000 | 32'h80 | (32'd2 << 8) | 32'd4;
        write_word(w); observe(w, span(w), "R6 reserved bits ignored");
        // R7: every source pattern
        for (int s = 0; s < 4; s++) begin
            w = 32'h0000_8000 | (32'(s) << 13) | (32'd1 << 8) | 32'd2;
            write_word(w); observe(w, 12, "R7 source pattern pulses");
        end
        // R8: rewrite in the middle of a period restarts the count
        w = 32'h0000_8000 | (32'd2 << 8) | 32'd6;
        write_word(w); observe(w, 17, "R8 before rewrite");
        write_word(w); observe(w, span(w), "R8 restart after rewrite");
        // Random words, mostly enabled (R2, R8, R9)
        for (int i = 0; i < 24; i++) begin
            w = $urandom();
            w[15] = ($urandom() % 8) != 0;
            if (($urandom() % 4) != 0 && w[6:0] > 7'd40) w[6:0] = w[6:0] % 7'd40;
            write_word(w); observe(w, span(w), "R2 random word period");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule